// File: doc/BRIEF.md
# Multilevel Interrupt Priority Controller

This block collects interrupt requests from a set of peripheral sources and chooses which one the CPU should take next. Each source is given one of three maskable levels (high, medium, low) through a two-bit level code. A separate non-maskable input ranks above all of them. The block raises a single request toward the CPU, together with the winning vector number, the level of that request and a select line that places the vector table in either the application area or the boot area.

The CPU answers with an acknowledge pulse when it takes the presented interrupt and with a return pulse when a handler ends. The block keeps one executing flag per level, so a new interrupt is only presented when it outranks every level already in service. Within the high and medium levels, and within the low level by default, the lowest source index wins. The low level can be switched to a rotating order that starts just after the most recently acknowledged low-level source.

Software sees three byte registers: the executing flags (read-only), the rotation pointer, and a control byte that holds the rotation enable, the vector area select and the three level enables. Clearing a level enable masks that level one cycle later than the write takes hold.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset all three registers read zero, no interrupt is requested, the vector and level outputs are zero and the vector area select is 0.
- R2: The control register is at address 2: bit 7 low-level rotation enable, bit 6 vector area select, bit 2 high enable, bit 1 medium enable, bit 0 low enable; bits 5:3 always read zero and writes to them are dropped. Address 3 reads zero.
- R3: The vector area select output equals control bit 6 from the cycle after the write (0 = application area, 1 = boot area).
- R4: High and medium requests, and low requests while rotation is off, are ordered by source index with the lowest index first.
- R5: With rotation on, the low-level search starts at pointer+1 and wraps through the sources; a pointer value of N_SRC-1 or above starts the search at source 0.
- R6: Levels rank non-maskable > high > medium > low; the presented request is the highest-ranked pending one. The non-maskable input needs no enable.
- R7: A set enable bit admits its level from the cycle after the write; after clearing it, the level is still admitted for one more cycle and masked from the cycle after that.
- R8: A request is presented only if its level ranks above every level whose executing flag is set.
- R9: An acknowledge while a request is presented sets the executing flag of that level; an acknowledge with no request present changes nothing.
- R10: A return pulse clears only the highest set executing flag.
- R11: The status register at address 0 reads bit 7 non-maskable, bit 2 high, bit 1 medium, bit 0 low executing flags, other bits zero; writes to it have no effect.
- R12: The pointer register at address 1 is written by software and is loaded with the source index on every acknowledged low-level interrupt (the acknowledge wins over a write in the same cycle).
- R13: Source level code per source: 0 unused, 1 low, 2 medium, 3 high. The vector output is the source index, or N_SRC for the non-maskable input; the level output is 0 none, 1 low, 2 medium, 3 high, 4 non-maskable; both are zero when no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Request line per source |
| src_lvl | input | 2*N_SRC | Two-bit level code per source |
| nmi_req | input | 1 | Non-maskable request |
| cpu_ack | input | 1 | CPU takes the presented interrupt |
| cpu_reti | input | 1 | CPU returns from a handler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_valid | output | 1 | Interrupt request toward the CPU |
| irq_vec | output | VEC_W | Winning vector number |
| irq_level | output | 3 | Level of the presented request |
| vec_base_sel | output | 1 | Vector area select |

## Verification
The bench targets the one-cycle grace after an enable is cleared, which a design that masks at once would lose and a design with two stages of delay would overrun. It drives the rotation pointer past the last source and onto it, where a wrong wrap would pick a source other than index 0, and mixes acknowledges with returns so that an incorrect nesting rule would either present a lower level during a higher handler or clear the wrong executing flag. Writes to the reserved control bits and to the status address check that neither leaks into the read data or the flags.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  typedef enum logic [2:0] {
    RK_NONE = 3'd0,
    RK_LOW  = 3'd1,
    RK_MED  = 3'd2,
    RK_HIGH = 3'd3,
    RK_NMI  = 3'd4
  } rank_e;

  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_LPTR = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam logic [1:0] SL_NONE = 2'd0;
  localparam logic [1:0] SL_LOW  = 2'd1;
  localparam logic [1:0] SL_MED  = 2'd2;
  localparam logic [1:0] SL_HIGH = 2'd3;

  localparam int CB_RR   = 7;
  localparam int CB_VSEL = 6;

  // highest rank among executing flags {nmi, high, med, low}
  function automatic rank_e top_rank(input logic [3:0] f);
    if (f[3])      return RK_NMI;
    else if (f[2]) return RK_HIGH;
    else if (f[1]) return RK_MED;
    else if (f[0]) return RK_LOW;
    else           return RK_NONE;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_lvl_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic [3:0]    exec_flags,
  input  logic          lo_ack,
  input  logic [IW-1:0] lo_idx,
  output logic [7:0]    rdata,
  output logic          rr_on,
  output logic          vsel,
  output logic [2:0]    ctrl_en,
  output logic [2:0]    en_eff,
  output logic [7:0]    lptr
);
  logic       rr_q, vsel_q;
  logic [2:0] en_q, en_d1;
  logic [7:0] lptr_q;
  logic       wr_ctrl, wr_lptr;

  assign wr_ctrl = wr && (addr == ADDR_CTRL);
  assign wr_lptr = wr && (addr == ADDR_LPTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q   <= 1'b0;
      vsel_q <= 1'b0;
      en_q   <= '0;
      en_d1  <= '0;
      lptr_q <= '0;
    end else begin
      en_d1 <= en_q;
      if (wr_ctrl) begin
        rr_q   <= wdata[CB_RR];
        vsel_q <= wdata[CB_VSEL];
        en_q   <= wdata[2:0];
      end
      if (lo_ack)       lptr_q <= 8'(lo_idx);
      else if (wr_lptr) lptr_q <= wdata;
    end
  end

  // a cleared enable keeps admitting its level for one more cycle
  assign en_eff  = en_q | en_d1;
  assign ctrl_en = en_q;
  assign rr_on   = rr_q;
  assign vsel    = vsel_q;
  assign lptr    = lptr_q;

  always_comb begin
    unique case (addr)
      ADDR_STAT: rdata = {exec_flags[3], 4'b0000, exec_flags[2:0]};
      ADDR_LPTR: rdata = lptr_q;
      ADDR_CTRL: rdata = {rr_q, vsel_q, 3'b000, en_q};
      default:   rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_src_sort.sv
module irq_src_sort
  import irq_lvl_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic [N_SRC-1:0]   src_req,
  input  logic [2*N_SRC-1:0] src_lvl,
  input  logic [2:0]         en_eff,
  output logic [N_SRC-1:0]   hi_m,
  output logic [N_SRC-1:0]   med_m,
  output logic [N_SRC-1:0]   lo_m
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [1:0] code;
    assign code     = src_lvl[2*i +: 2];
    assign hi_m[i]  = src_req[i] && (code == SL_HIGH) && en_eff[2];
    assign med_m[i] = src_req[i] && (code == SL_MED)  && en_eff[1];
    assign lo_m[i]  = src_req[i] && (code == SL_LOW)  && en_eff[0];
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC  = 16,
  parameter int IW     = 4,
  parameter bit ROTATE = 1'b0
) (
  input  logic [N_SRC-1:0] mask,
  input  logic             rr_on,
  input  logic [7:0]       ptr,
  output logic             any,
  output logic [IW-1:0]    idx,
  output logic [IW-1:0]    start
);
  function automatic logic [IW-1:0] next_start(input logic [7:0] p);
    if (int'(p) >= N_SRC - 1) return '0;
    else return IW'(int'(p) + 1);
  endfunction

  function automatic logic [IW-1:0] first_from(input logic [N_SRC-1:0] m,
                                               input logic [IW-1:0]    s);
    logic [IW-1:0] r;
    logic          hit;
    r   = '0;
    hit = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      int j;
      j = (int'(s) + k) % N_SRC;
      if (!hit && m[j]) begin
        r   = IW'(j);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign start = (ROTATE && rr_on) ? next_start(ptr) : '0;
  assign any   = |mask;
  assign idx   = first_from(mask, start);
endmodule

// File: rtl/irq_exec_track.sv
module irq_exec_track
  import irq_lvl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  rank_e      take_rank,
  input  logic       reti,
  output logic [3:0] flags,
  output rank_e      cur_rank
);
  logic [3:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (reti) begin
      if (flags_d[3])      flags_d[3] = 1'b0;
      else if (flags_d[2]) flags_d[2] = 1'b0;
      else if (flags_d[1]) flags_d[1] = 1'b0;
      else if (flags_d[0]) flags_d[0] = 1'b0;
    end
    if (take) begin
      case (take_rank)
        RK_NMI:  flags_d[3] = 1'b1;
        RK_HIGH: flags_d[2] = 1'b1;
        RK_MED:  flags_d[1] = 1'b1;
        RK_LOW:  flags_d[0] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags    = flags_q;
  assign cur_rank = top_rank(flags_q);
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int VEC_W = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_req,
  input  logic [2*N_SRC-1:0] src_lvl,
  input  logic               nmi_req,
  input  logic               cpu_ack,
  input  logic               cpu_reti,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [2:0]         irq_level,
  output logic               vec_base_sel
);
  // named internal events
  logic             rr_on, vsel;
  logic [2:0]       ctrl_en, en_eff;
  logic [7:0]       lptr;
  logic [3:0]       exec_flags;
  rank_e            cur_rank, pend_rank;
  logic [N_SRC-1:0] hi_m, med_m, lo_m;
  logic             hi_any, med_any, lo_any, nmi_pend;
  logic [IW-1:0]    hi_idx, med_idx, lo_idx;
  logic [IW-1:0]    hi_start, med_start, lo_start;
  logic             take, lo_ack;
  logic [VEC_W-1:0] win_vec;

  irq_regs #(.N_SRC(N_SRC), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .exec_flags(exec_flags), .lo_ack(lo_ack), .lo_idx(lo_idx),
    .rdata(reg_rdata), .rr_on(rr_on), .vsel(vsel), .ctrl_en(ctrl_en),
    .en_eff(en_eff), .lptr(lptr)
  );

  irq_src_sort #(.N_SRC(N_SRC)) u_sort (
    .src_req(src_req), .src_lvl(src_lvl), .en_eff(en_eff),
    .hi_m(hi_m), .med_m(med_m), .lo_m(lo_m)
  );

  irq_pick #(.N_SRC(N_SRC), .IW(IW), .ROTATE(1'b0)) u_pick_hi (
    .mask(hi_m), .rr_on(rr_on), .ptr(lptr),
    .any(hi_any), .idx(hi_idx), .start(hi_start)
  );
  irq_pick #(.N_SRC(N_SRC), .IW(IW), .ROTATE(1'b0)) u_pick_med (
    .mask(med_m), .rr_on(rr_on), .ptr(lptr),
    .any(med_any), .idx(med_idx), .start(med_start)
  );
  irq_pick #(.N_SRC(N_SRC), .IW(IW), .ROTATE(1'b1)) u_pick_lo (
    .mask(lo_m), .rr_on(rr_on), .ptr(lptr),
    .any(lo_any), .idx(lo_idx), .start(lo_start)
  );

  irq_exec_track u_exec (
    .clk(clk), .rst_n(rst_n), .take(take), .take_rank(pend_rank),
    .reti(cpu_reti), .flags(exec_flags), .cur_rank(cur_rank)
  );

  assign nmi_pend = nmi_req && !exec_flags[3];

  always_comb begin
    if (nmi_pend) begin
      pend_rank = RK_NMI;
      win_vec   = VEC_W'(N_SRC);
    end else if (hi_any) begin
      pend_rank = RK_HIGH;
      win_vec   = VEC_W'(hi_idx);
    end else if (med_any) begin
      pend_rank = RK_MED;
      win_vec   = VEC_W'(med_idx);
    end else if (lo_any) begin
      pend_rank = RK_LOW;
      win_vec   = VEC_W'(lo_idx);
    end else begin
      pend_rank = RK_NONE;
      win_vec   = '0;
    end
  end

  assign irq_valid    = pend_rank > cur_rank;
  assign irq_level    = irq_valid ? 3'(pend_rank) : 3'd0;
  assign irq_vec      = irq_valid ? win_vec : '0;
  assign take         = cpu_ack && irq_valid;
  assign lo_ack       = take && (pend_rank == RK_LOW);
  assign vec_base_sel = vsel;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_lvl_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int VEC_W = IW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_req,
  input logic             cpu_reti,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec,
  input logic [2:0]       irq_level,
  input logic             vec_base_sel,
  input logic [3:0]       exec_flags,
  input rank_e            cur_rank,
  input logic [2:0]       ctrl_en,
  input logic [7:0]       lptr,
  input logic             take
);
  logic [3:0] lvl_bit;
  always_comb begin
    case (irq_level)
      3'd4:    lvl_bit = 4'b1000;
      3'd3:    lvl_bit = 4'b0100;
      3'd2:    lvl_bit = 4'b0010;
      3'd1:    lvl_bit = 4'b0001;
      default: lvl_bit = 4'b0000;
    endcase
  end

  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CTRL) |-> (reg_rdata[5:3] == 3'b000));

  assert_vsel_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CTRL) |=> (vec_base_sel == $past(reg_wdata[6])));

  assert_nmi_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !exec_flags[3]) |-> (irq_valid && irq_level == 3'd4));

  assert_hi_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level == 3'd3) |-> (ctrl_en[2] || $past(ctrl_en[2])));

  assert_lo_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level == 3'd1) |-> (ctrl_en[0] || $past(ctrl_en[0])));

  assert_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > 3'(cur_rank)));

  assert_ack_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((exec_flags & $past(lvl_bit)) != 4'b0000));

  assert_reti_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reti && !take && exec_flags != 4'b0000) |=>
      ($countones(exec_flags) == $countones($past(exec_flags)) - 1));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !cpu_reti) |=> $stable(exec_flags));

  assert_ptr_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_level == 3'd1) |=> (lptr == 8'($past(irq_vec))));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .cpu_reti(cpu_reti),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
  .irq_level(irq_level), .vec_base_sel(vec_base_sel),
  .exec_flags(exec_flags), .cur_rank(cur_rank), .ctrl_en(ctrl_en),
  .lptr(lptr), .take(take)
);

// File: tb/test_irq_level_ctrl.sv
`timescale 1ns/1ps
module test_irq_level_ctrl;
  localparam int N     = 16;
  localparam int VEC_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     src_req = '0;
  logic [2*N-1:0]   src_lvl = '0;
  logic             nmi_req = 1'b0;
  logic             cpu_ack = 1'b0;
  logic             cpu_reti = 1'b0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [7:0]       reg_wdata = 8'd0;
  logic [7:0]       reg_rdata;
  logic             irq_valid;
  logic [VEC_W-1:0] irq_vec;
  logic [2:0]       irq_level;
  logic             vec_base_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  logic [7:0] m_ctrl = 8'h00;
  logic [2:0] m_enq  = 3'b000;
  logic [7:0] m_lptr = 8'h00;
  logic [3:0] m_exec = 4'b0000;

  always #4 clk = ~clk;

  irq_level_ctrl #(.N_SRC(N)) i_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_lvl(src_lvl),
    .nmi_req(nmi_req), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_level(irq_level), .vec_base_sel(vec_base_sel)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // lowest set index, scanning downward so the last hit is the lowest
  function automatic int low_first(input logic [N-1:0] m);
    int r = -1;
    for (int i = N - 1; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  function automatic int rotate_first(input logic [N-1:0] m, input logic [7:0] p);
    int s = (int'(p) >= N - 1) ? 0 : int'(p) + 1;
    for (int k = 0; k < N; k++) if (m[(s + k) % N]) return (s + k) % N;
    return -1;
  endfunction

  function automatic int exec_rank(input logic [3:0] e);
    for (int b = 3; b >= 0; b--) if (e[b]) return b + 1;
    return 0;
  endfunction

  task automatic step(input string tag);
    logic [2:0]   en;
    logic [N-1:0] mh, mm, ml;
    int           prank, pvec, erank, ev, el;
    logic [7:0]   er;
    bit           ev_ok;
    #1;
    en = m_ctrl[2:0] | m_enq;
    for (int i = 0; i < N; i++) begin
      mh[i] = src_req[i] && src_lvl[2*i +: 2] == 2'd3 && en[2];
      mm[i] = src_req[i] && src_lvl[2*i +: 2] == 2'd2 && en[1];
      ml[i] = src_req[i] && src_lvl[2*i +: 2] == 2'd1 && en[0];
    end
    prank = 0; pvec = 0;
    if (nmi_req && !m_exec[3]) begin prank = 4; pvec = N; end
    else if (mh != 0) begin prank = 3; pvec = low_first(mh); end
    else if (mm != 0) begin prank = 2; pvec = low_first(mm); end
    else if (ml != 0) begin
      prank = 1;
      pvec  = m_ctrl[7] ? rotate_first(ml, m_lptr) : low_first(ml);
    end
    erank = exec_rank(m_exec);
    ev_ok = prank > erank;
    ev    = ev_ok ? pvec : 0;
    el    = ev_ok ? prank : 0;
    case (reg_addr)
      2'd0: er = {m_exec[3], 4'b0000, m_exec[2:0]};
      2'd1: er = m_lptr;
      2'd2: er = m_ctrl;
      default: er = 8'h00;
    endcase
    chk(tag, "irq_valid", int'(irq_valid), int'(ev_ok));
    chk(tag, "irq_vec", int'(irq_vec), ev);
    chk(tag, "irq_level", int'(irq_level), el);
    chk(tag, "vec_base_sel", int'(vec_base_sel), int'(m_ctrl[6]));
    chk(tag, "reg_rdata", int'(reg_rdata), int'(er));
    @(posedge clk);
    m_enq = m_ctrl[2:0];
    if (cpu_reti) begin
      if (m_exec[3]) m_exec[3] = 1'b0;
      else if (m_exec[2]) m_exec[2] = 1'b0;
      else if (m_exec[1]) m_exec[1] = 1'b0;
      else if (m_exec[0]) m_exec[0] = 1'b0;
    end
    if (cpu_ack && ev_ok) m_exec[prank - 1] = 1'b1;
    if (cpu_ack && ev_ok && prank == 1) m_lptr = 8'(pvec);
    else if (reg_wr && reg_addr == 2'd1) m_lptr = reg_wdata;
    if (reg_wr && reg_addr == 2'd2) m_ctrl = reg_wdata & 8'hC7;
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_ack = 0; cpu_reti = 0; reg_wr = 0; nmi_req = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input string tag);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(tag);
    reg_wr = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every register
    for (int a = 0; a < 3; a++) begin reg_addr = 2'(a); step("R1"); end
    // R2 / R3: reserved bits dropped, area select follows bit 6
    wr_reg(2'd2, 8'hFF, "R2");
    reg_addr = 2'd2; step("R2 R3");
    reg_addr = 2'd3; step("R2");
    // R11: write to status has no effect
    wr_reg(2'd0, 8'hFF, "R11");
    reg_addr = 2'd0; step("R11");
    // R13/R4: high sources 5 and 9, medium 2; lowest high wins
    src_lvl = '0;
    src_lvl[2*5 +: 2] = 2'd3; src_lvl[2*9 +: 2] = 2'd3; src_lvl[2*2 +: 2] = 2'd2;
    src_req = '0; src_req[5] = 1; src_req[9] = 1; src_req[2] = 1;
    step("R4 R13");
    // R7: clear high enable, one cycle grace, then masked
    wr_reg(2'd2, 8'h03, "R7");
    step("R7");
    step("R7");
    // R9/R8: take medium 2, then low cannot enter
    src_lvl[2*7 +: 2] = 2'd1; src_req[7] = 1;
    cpu_ack = 1; step("R9"); cpu_ack = 0;
    reg_addr = 2'd0; step("R8 R11");
    // R6: NMI preempts during medium handler
    nmi_req = 1; step("R6");
    cpu_ack = 1; step("R6 R9"); cpu_ack = 0; nmi_req = 0;
    // R10: return clears NMI first, then medium
    cpu_reti = 1; step("R10"); step("R10"); cpu_reti = 0;
    // R5/R12: rotation with pointer at and above the last index
    src_req = '0; src_lvl = '0;
    for (int i = 0; i < N; i++) src_lvl[2*i +: 2] = 2'd1;
    src_req[0] = 1; src_req[4] = 1; src_req[N-1] = 1;
    wr_reg(2'd2, 8'h81, "R5");
    wr_reg(2'd1, 8'(N - 1), "R5 R12");
    step("R5");
    wr_reg(2'd1, 8'd200, "R5 R12");
    step("R5");
    wr_reg(2'd1, 8'd3, "R5 R12");
    cpu_ack = 1; step("R5 R12"); cpu_ack = 0;
    reg_addr = 2'd1; step("R12");
    cpu_reti = 1; step("R10"); cpu_reti = 0;
    // R9: acknowledge with nothing presented
    src_req = '0;
    cpu_ack = 1; reg_addr = 2'd0; step("R9"); cpu_ack = 0;
    // constrained random traffic
    for (int blk = 0; blk < 60; blk++) begin
      for (int i = 0; i < N; i++) src_lvl[2*i +: 2] = 2'($urandom_range(0, 3));
      wr_reg(2'd2, 8'($urandom_range(0, 255)) | 8'h07, "R4 R5 R6");
      for (int c = 0; c < 50; c++) begin
        src_req  = N'($urandom());
        nmi_req  = ($urandom_range(0, 19) == 0);
        cpu_ack  = ($urandom_range(0, 9) < 4);
        cpu_reti = ($urandom_range(0, 9) < 3);
        reg_addr = 2'($urandom_range(0, 3));
        reg_wr   = ($urandom_range(0, 19) == 0);
        reg_wdata = 8'($urandom_range(0, 255));
        step("R4 R5 R6 R7 R8 R9 R10 R11 R12 R13");
      end
      idle();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule